// File: doc/BRIEF.md
# Cache Line Refill Controller with Load-Through

This block sits between a processor read port, the lookup result of a cache, a slower main memory that returns a line as a burst, and the write port of the cache data array. A processor read is taken when the controller is ready. The cycle after acceptance is the cache access cycle, where the external lookup reports hit or miss. A hit is returned one cycle later. A miss starts a refill of the whole 8-word line. Memory returns the words in ascending order. Each word is written into the line in the cycle it arrives.

The processor is not held for the whole refill. As soon as the word it asked for has been written, that word is returned one cycle later, and the processor may go on with new requests. The rest of the line keeps streaming into the cache during that time. The line becomes valid only after its eighth word has been written, which the controller signals with a completion pulse. Only one refill runs at a time. A new miss that arrives while a refill is running waits until the refill engine is idle, and then its cache access is repeated.

Addresses are word addresses. The low log2(WORDS) bits select the word within a line, and the remaining upper bits form the line address.

Top module: `refill_loadthru`

## Requirements
- R1: A read accepted on a clock edge (cpu_req_i high while cpu_ready_o high) drives look_en_o with look_addr_o equal to the accepted address during the next cycle, which is the access cycle. If look_hit_i is high in that cycle, cpu_rvalid_o is high for one cycle in the following cycle, with cpu_rdata_o equal to the look_data_i of the access cycle.
- R2: A miss in the access cycle while no refill is running produces exactly one mem_req_o pulse, one cycle wide, in the cycle right after the access cycle. During that pulse, mem_line_o equals the upper (line) bits of the address.
- R3: During a refill, every cycle with mem_rvalid_i high is a write cycle with fill_we_o high. In that cycle fill_line_o is the line being refilled, fill_data_o equals mem_rdata_i, and fill_word_o takes the values 0, 1, 2 ... 7 in beat order.
- R4: Load-through: cpu_rvalid_o rises in the cycle after the write of the requested word, and cpu_rdata_o carries that word. Assume memory shows the first word in the 10th cycle, counting the mem_req_o cycle as the first, and one further word in each following cycle. Then the response for word k arrives 11+k cycles after the access cycle. For word 7 this gives a penalty of 19 cycles, counted from the access cycle to the delivery cycle inclusive.
- R5: fill_done_o is a one-cycle pulse in the cycle after the eighth write of a refill, and it never comes earlier.
- R6: cpu_ready_o is high in the cycle after each response. While a refill is still writing its later words, new reads are accepted, and a read that hits is answered with the R1 timing.
- R7: A miss in an access cycle while a refill is busy raises no mem_req_o. The refill counts as busy up to and including its fill_done_o cycle. The access is repeated two cycles after the fill_done_o cycle and is then handled as a hit or as a new miss.
- R8: While rst_n is low on a clock edge, the outputs after that edge are cpu_ready_o=1, cpu_rvalid_o=0, mem_req_o=0, fill_we_o=0 and fill_done_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_i | input | 1 | Processor read request |
| cpu_addr_i | input | ADDR_W | Word address of the read |
| cpu_ready_o | output | 1 | Controller can accept a read |
| cpu_rvalid_o | output | 1 | Read data valid, one cycle |
| cpu_rdata_o | output | DATA_W | Read data |
| look_en_o | output | 1 | Access cycle in progress |
| look_addr_o | output | ADDR_W | Address presented to the lookup |
| look_hit_i | input | 1 | Lookup reports a valid line |
| look_data_i | input | DATA_W | Word read from the cache on a hit |
| mem_req_o | output | 1 | Line fetch request pulse |
| mem_line_o | output | ADDR_W-log2(WORDS) | Line address to fetch |
| mem_rvalid_i | input | 1 | Burst word valid |
| mem_rdata_i | input | DATA_W | Burst word |
| fill_we_o | output | 1 | Write one word into the line |
| fill_line_o | output | ADDR_W-log2(WORDS) | Line being written |
| fill_word_o | output | log2(WORDS) | Word position within the line |
| fill_data_o | output | DATA_W | Word to write |
| fill_done_o | output | 1 | All words written; set the line valid |

## Verification
The bench requests the first and the last word of a line. A design that waited for the whole block, or that counted the memory latency from the wrong cycle, would deliver word 0 eight cycles late, or deliver word 7 on some cycle other than the 19th. The bench also hits in other lines while a refill is still streaming. A controller that held the processor until the end of the line would return those hits late. It issues a second miss during a refill, including one to the very line being filled. A design without the stall would start a second memory burst, and one that set the line valid too early would return words that have not yet arrived. Finally, the bench compares every line write against the memory contents and the ascending word order, so a misnumbered word or a write dropped after the processor has been released shows up as a wrong hit later on.

// File: rtl/rl_pkg.sv
// Package: shared state encodings for the refill controller.
// Assumes one refill engine and one outstanding processor read.
package rl_pkg;

    // Processor-side sequencer states.
    typedef enum logic [2:0] {
        CPU_IDLE  = 3'd0,
        CPU_LOOK  = 3'd1,
        CPU_RETRY = 3'd2,
        CPU_WAIT  = 3'd3,
        CPU_RESP  = 3'd4
    } cpu_st_e;

    // Refill engine states.
    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_REQ  = 2'd1,
        ENG_FILL = 2'd2,
        ENG_DONE = 2'd3
    } eng_st_e;

endpackage

// File: rtl/rl_fill_engine.sv
// Refill engine: fetches one line from main memory and writes every
// returned word into the cache line in arrival order.
// Assumes memory returns exactly WORDS beats, ascending from word 0,
// each flagged by mem_rvalid_i, and starts no earlier than the cycle
// after the request. start_i is raised only while the engine is idle.
module rl_fill_engine
    import rl_pkg::*;
#(
    parameter int LINE_W = 13,
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int OFF_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LINE_W-1:0] start_line_i,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic [LINE_W-1:0] mem_line_o,
    output logic              fill_we_o,
    output logic [LINE_W-1:0] fill_line_o,
    output logic [OFF_W-1:0]  fill_word_o,
    output logic [DATA_W-1:0] fill_data_o,
    output logic              fill_done_o
);

    localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(WORDS - 1);

    eng_st_e           st_q, st_d;
    logic [LINE_W-1:0] line_q;
    logic [OFF_W-1:0]  cnt_q;
    logic [WORDS-1:0]  arrived_q;
    logic              beat;

    assign beat = (st_q == ENG_FILL) && mem_rvalid_i;

    // Next-state choice for the refill sequence.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ENG_IDLE: if (start_i) st_d = ENG_REQ;
            ENG_REQ:  st_d = ENG_FILL;
            ENG_FILL: if (beat && (cnt_q == LAST_WORD)) st_d = ENG_DONE;
            ENG_DONE: st_d = ENG_IDLE;
            default:  st_d = ENG_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ENG_IDLE;
        else        st_q <= st_d;
    end

    // Holds the line address for the length of one refill.
    always_ff @(posedge clk) begin
        if (!rst_n)                            line_q <= '0;
        else if ((st_q == ENG_IDLE) && start_i) line_q <= start_line_i;
    end

    // Beat counter: position of the next word to be written.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (st_q == ENG_REQ) cnt_q <= '0;
        else if (beat)            cnt_q <= cnt_q + OFF_W'(1);
    end

    // One arrival flag per word of the line, cleared at each new request.
    for (genvar w = 0; w < WORDS; w++) begin : g_arrived
        always_ff @(posedge clk) begin
            if (!rst_n)                              arrived_q[w] <= 1'b0;
            else if (st_q == ENG_REQ)                arrived_q[w] <= 1'b0;
            else if (beat && (cnt_q == OFF_W'(w)))   arrived_q[w] <= 1'b1;
        end
    end

    assign busy_o      = (st_q != ENG_IDLE);
    assign mem_req_o   = (st_q == ENG_REQ);
    assign mem_line_o  = line_q;
    assign fill_we_o   = beat;
    assign fill_line_o = line_q;
    assign fill_word_o = cnt_q;
    assign fill_data_o = mem_rdata_i;
    assign fill_done_o = (st_q == ENG_DONE);

    // ---- assertions ----
    logic [OFF_W-1:0] prev_word;
    assign prev_word = fill_word_o - OFF_W'(1);

    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    assert_req_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> $past(start_i));

    assert_word_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we_o |-> !arrived_q[fill_word_o]);

    assert_word_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we_o && (fill_word_o != '0)) |-> arrived_q[prev_word]);

    assert_done_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done_o |-> (&arrived_q));

    assert_no_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

endmodule

// File: rtl/rl_cpu_seq.sv
// Processor-side sequencer: accepts one read, runs the access cycle,
// and on a miss either starts the refill engine or waits for it to go
// idle and repeats the access. While a refill runs for this read, it
// watches the line writes for the requested word (load-through).
// Assumes the lookup answers within the access cycle.
module rl_cpu_seq
    import rl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 3,
    parameter int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              look_hit_i,
    input  logic              eng_busy_i,
    input  logic              fill_we_i,
    input  logic [LINE_W-1:0] fill_line_i,
    input  logic [OFF_W-1:0]  fill_word_i,
    output logic              cpu_ready_o,
    output logic              look_en_o,
    output logic [ADDR_W-1:0] look_addr_o,
    output logic              start_o,
    output logic [LINE_W-1:0] start_line_o,
    output logic              take_look_o,
    output logic              take_fill_o
);

    cpu_st_e           st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic              crit_match;

    assign crit_match = fill_we_i
                     && (fill_line_i == addr_q[ADDR_W-1:OFF_W])
                     && (fill_word_i == addr_q[OFF_W-1:0]);

    // Next-state choice for one processor read.
    always_comb begin
        st_d = st_q;
        case (st_q)
            CPU_IDLE:  if (cpu_req_i) st_d = CPU_LOOK;
            CPU_LOOK: begin
                if (look_hit_i)       st_d = CPU_RESP;
                else if (!eng_busy_i) st_d = CPU_WAIT;
                else                  st_d = CPU_RETRY;
            end
            CPU_RETRY: if (!eng_busy_i) st_d = CPU_LOOK;
            CPU_WAIT:  if (crit_match)  st_d = CPU_RESP;
            CPU_RESP:  st_d = CPU_IDLE;
            default:   st_d = CPU_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CPU_IDLE;
        else        st_q <= st_d;
    end

    // Captures the read address when the request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                               addr_q <= '0;
        else if ((st_q == CPU_IDLE) && cpu_req_i) addr_q <= cpu_addr_i;
    end

    assign cpu_ready_o  = (st_q == CPU_IDLE);
    assign look_en_o    = (st_q == CPU_LOOK);
    assign look_addr_o  = addr_q;
    assign start_o      = (st_q == CPU_LOOK) && !look_hit_i && !eng_busy_i;
    assign start_line_o = addr_q[ADDR_W-1:OFF_W];
    assign take_look_o  = (st_q == CPU_LOOK) && look_hit_i;
    assign take_fill_o  = (st_q == CPU_WAIT) && crit_match;

    // ---- assertions ----
    assert_wait_has_refill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CPU_WAIT) |-> eng_busy_i);

    assert_retry_no_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CPU_RETRY) |=> !start_o || $past(!eng_busy_i));

endmodule

// File: rtl/rl_resp_path.sv
// Response register: holds the word returned to the processor, taken
// either from the lookup on a hit or from the line write on load-through.
// Assumes at most one of the two capture strobes is high in a cycle.
module rl_resp_path #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_look_i,
    input  logic              take_fill_i,
    input  logic [DATA_W-1:0] look_data_i,
    input  logic [DATA_W-1:0] fill_data_i,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] rdata_o
);

    // One-cycle valid strobe for each captured word.
    always_ff @(posedge clk) begin
        if (!rst_n) rvalid_o <= 1'b0;
        else        rvalid_o <= take_look_i || take_fill_i;
    end

    // Data register, loaded from whichever source is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)           rdata_o <= '0;
        else if (take_look_i) rdata_o <= look_data_i;
        else if (take_fill_i) rdata_o <= fill_data_i;
    end

    assert_one_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_look_i && take_fill_i));

endmodule

// File: rtl/refill_loadthru.sv
// Top: cache line refill controller with load-through. Connects the
// processor sequencer, the refill engine and the response register.
// Assumes external tag/valid storage that answers look_en_o in the same
// cycle and sets a line valid on fill_done_o.
module refill_loadthru #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int WORDS  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cpu_req_i,
    input  logic [ADDR_W-1:0]                 cpu_addr_i,
    output logic                              cpu_ready_o,
    output logic                              cpu_rvalid_o,
    output logic [DATA_W-1:0]                 cpu_rdata_o,
    output logic                              look_en_o,
    output logic [ADDR_W-1:0]                 look_addr_o,
    input  logic                              look_hit_i,
    input  logic [DATA_W-1:0]                 look_data_i,
    output logic                              mem_req_o,
    output logic [ADDR_W-$clog2(WORDS)-1:0]   mem_line_o,
    input  logic                              mem_rvalid_i,
    input  logic [DATA_W-1:0]                 mem_rdata_i,
    output logic                              fill_we_o,
    output logic [ADDR_W-$clog2(WORDS)-1:0]   fill_line_o,
    output logic [$clog2(WORDS)-1:0]          fill_word_o,
    output logic [DATA_W-1:0]                 fill_data_o,
    output logic                              fill_done_o
);

    localparam int OFF_W  = $clog2(WORDS);
    localparam int LINE_W = ADDR_W - OFF_W;

    logic              eng_busy;
    logic              start;
    logic [LINE_W-1:0] start_line;
    logic              take_look;
    logic              take_fill;

    rl_cpu_seq #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .LINE_W (LINE_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req_i    (cpu_req_i),
        .cpu_addr_i   (cpu_addr_i),
        .look_hit_i   (look_hit_i),
        .eng_busy_i   (eng_busy),
        .fill_we_i    (fill_we_o),
        .fill_line_i  (fill_line_o),
        .fill_word_i  (fill_word_o),
        .cpu_ready_o  (cpu_ready_o),
        .look_en_o    (look_en_o),
        .look_addr_o  (look_addr_o),
        .start_o      (start),
        .start_line_o (start_line),
        .take_look_o  (take_look),
        .take_fill_o  (take_fill)
    );

    rl_fill_engine #(
        .LINE_W (LINE_W),
        .DATA_W (DATA_W),
        .WORDS  (WORDS),
        .OFF_W  (OFF_W)
    ) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .start_line_i (start_line),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .busy_o       (eng_busy),
        .mem_req_o    (mem_req_o),
        .mem_line_o   (mem_line_o),
        .fill_we_o    (fill_we_o),
        .fill_line_o  (fill_line_o),
        .fill_word_o  (fill_word_o),
        .fill_data_o  (fill_data_o),
        .fill_done_o  (fill_done_o)
    );

    rl_resp_path #(
        .DATA_W (DATA_W)
    ) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_look_i (take_look),
        .take_fill_i (take_fill),
        .look_data_i (look_data_i),
        .fill_data_i (fill_data_o),
        .rvalid_o    (cpu_rvalid_o),
        .rdata_o     (cpu_rdata_o)
    );

    // ---- assertions ----
    assert_hit_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rvalid_o && $past(look_en_o && look_hit_i)) |-> (cpu_rdata_o == $past(look_data_i)));

    assert_fill_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rvalid_o && !$past(look_en_o)) |-> ($past(fill_we_o) && (cpu_rdata_o == $past(fill_data_o))));

    assert_ready_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid_o |=> cpu_ready_o);

    assert_reset_state_R8: assert property (@(posedge clk)
        !rst_n |=> (cpu_ready_o && !cpu_rvalid_o && !mem_req_o && !fill_we_o && !fill_done_o));

endmodule

// File: tb/refill_loadthru_tb_top.sv
// Scoreboard bench: the driver predicts each response (data and cycle)
// and each memory request from the requirements and queues them; a
// monitor compares what the design produces. A memory model and a small
// cache model (valid bits plus data) surround the design.
module refill_loadthru_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NW = 8;
    localparam int NEVER = 1000000000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_ready, cpu_rvalid;
    logic [DW-1:0] cpu_rdata;
    logic          look_en;
    logic [AW-1:0] look_addr;
    logic          look_hit;
    logic [DW-1:0] look_data;
    logic          mem_req;
    logic [4:0]    mem_line;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          fill_we;
    logic [4:0]    fill_line;
    logic [2:0]    fill_word;
    logic [DW-1:0] fill_data;
    logic          fill_done;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;

    bit [DW-1:0] cache_mem [256];
    bit          line_ok   [32];

    typedef struct { logic [DW-1:0] data; int at; string tag; } resp_t;
    typedef struct { logic [4:0] line; int at; } mreq_t;
    resp_t resp_q[$];
    mreq_t mreq_q[$];

    int valid_from [32];
    int busy_thru = -1;

    refill_loadthru #(.ADDR_W(AW), .DATA_W(DW), .WORDS(NW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_i(cpu_req), .cpu_addr_i(cpu_addr),
        .cpu_ready_o(cpu_ready), .cpu_rvalid_o(cpu_rvalid), .cpu_rdata_o(cpu_rdata),
        .look_en_o(look_en), .look_addr_o(look_addr),
        .look_hit_i(look_hit), .look_data_i(look_data),
        .mem_req_o(mem_req), .mem_line_o(mem_line),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .fill_we_o(fill_we), .fill_line_o(fill_line), .fill_word_o(fill_word),
        .fill_data_o(fill_data), .fill_done_o(fill_done)
    );

    assign look_hit  = line_ok[look_addr[7:3]];
    assign look_data = cache_mem[look_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    function automatic logic [DW-1:0] mem_val(int a);
        return {8'h5A, 8'(a), 8'(~a), 8'(a * 3)};
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: waits for ready, presents one read, predicts its outcome.
    task automatic issue(logic [AW-1:0] addr);
        int    l;
        int    line;
        int    k;
        resp_t e;
        bit    retried;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req  = 1'b1;
        cpu_addr = addr;
        l        = cyc + 1;
        line     = int'(addr[7:3]);
        k        = int'(addr[2:0]);
        retried  = 1'b0;
        e.data   = mem_val(int'(addr));
        forever begin
            if (valid_from[line] <= l) begin
                e.at  = l + 1;
                e.tag = retried ? "R7" : ((busy_thru >= l) ? "R6" : "R1");
                break;
            end else if (busy_thru >= l) begin
                l       = busy_thru + 2;
                retried = 1'b1;
            end else begin
                mreq_q.push_back('{line: 5'(line), at: l + 1});
                e.at             = l + 11 + k;
                e.tag            = retried ? "R7" : "R4";
                valid_from[line] = l + 18;
                busy_thru        = l + 18;
                break;
            end
        end
        resp_q.push_back(e);
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    // Memory model: first word in the 10th cycle counting the request cycle.
    initial forever begin
        @(negedge clk);
        if (rst_n && mem_req) begin
            int ln;
            ln = int'(mem_line);
            repeat (9) @(negedge clk);
            for (int w = 0; w < NW; w++) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem_val(ln * NW + w);
                @(negedge clk);
            end
            mem_rvalid = 1'b0;
        end
    end

    // Monitor: compares responses, requests and line writes late in each cycle.
    initial begin
        int cur_line;
        int beat;
        cur_line = 0;
        beat     = 0;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (rst_n) begin
                if (cpu_rvalid) begin
                    if (resp_q.size() == 0) begin
                        check(1'b0, "R4", "unexpected response", cpu_rdata, 0);
                    end else begin
                        resp_t e;
                        e = resp_q.pop_front();
                        check(cpu_rdata == e.data, e.tag, "response data", cpu_rdata, e.data);
                        check(cyc == e.at, e.tag, "response cycle", cyc, e.at);
                    end
                end
                if (mem_req) begin
                    if (mreq_q.size() == 0) begin
                        check(1'b0, "R7", "memory request while stalled", mem_line, 0);
                    end else begin
                        mreq_t m;
                        m = mreq_q.pop_front();
                        check(mem_line == m.line, "R2", "request line", mem_line, m.line);
                        check(cyc == m.at, "R2", "request cycle", cyc, m.at);
                        cur_line = int'(mem_line);
                        beat     = 0;
                    end
                end
                if (fill_we) begin
                    check((int'(fill_line) == cur_line) && (int'(fill_word) == beat),
                          "R3", "write position", {fill_line, fill_word}, cur_line * NW + beat);
                    check(fill_data == mem_val(cur_line * NW + beat),
                          "R3", "write data", fill_data, mem_val(cur_line * NW + beat));
                    cache_mem[{fill_line, fill_word}] = fill_data;
                    beat++;
                end
                if (fill_done) begin
                    check(beat == NW, "R5", "words before completion", beat, NW);
                    line_ok[cur_line] = 1'b1;
                end
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired: actual %0d cycles expected fewer", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Main sequence.
    initial begin
        foreach (valid_from[i]) valid_from[i] = NEVER;
        repeat (3) @(negedge clk);
        check(cpu_ready == 1'b1, "R8", "reset ready", cpu_ready, 1);
        check(cpu_rvalid == 1'b0, "R8", "reset rvalid", cpu_rvalid, 0);
        check(mem_req == 1'b0, "R8", "reset mem_req", mem_req, 0);
        check((fill_we == 1'b0) && (fill_done == 1'b0), "R8", "reset fill", {fill_we, fill_done}, 0);
        rst_n = 1'b1;

        issue(8'h10);   // R4: miss, word 0 released early
        issue(8'h15);   // R7: same line while still filling
        issue(8'h2F);   // R4: word 7, full 19-cycle penalty
        issue(8'h2A);   // R1: hit
        issue(8'h4B);   // R4: miss, word 3
        issue(8'h11);   // R6: hit while refill streams
        issue(8'h2C);   // R6: second hit during refill
        issue(8'h62);   // R7: miss stalled behind the refill
        issue(8'h49);   // R1: hit on the earlier line
        issue(8'hFE);   // R4: top line, word 6
        issue(8'h00);   // R7: stalled miss to line 0
        issue(8'hFF);   // R1: hit top word
        issue(8'h01);   // R1: hit line 0

        repeat (40) @(negedge clk);
        check(resp_q.size() == 0, "R4", "responses outstanding", resp_q.size(), 0);
        check(mreq_q.size() == 0, "R2", "requests outstanding", mreq_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule